// File: doc/BRIEF.md
# Dual-Channel Serial Configuration Loader

This block takes a 23-bit configuration word over a slow three-wire serial link (data, serial clock, load enable) and holds it for one of two synthesizer channels, transmit or receive. The word carries its own routing bit, so a single shift register serves both channel registers. The serial lines are asynchronous to the system clock. Each line passes through a two-stage synchroniser, and the block acts on edges of the synchronised levels. The serial timing (each setup, hold and pulse width of at least 1 µs) is far slower than the system clock, so every serial edge is seen as a clean single-cycle event.

Each channel register splits its word into fields and presents them as plain levels to the downstream divider and phase-detector logic. These fields are an 11-bit main divide count, a 7-bit swallow count, a phase polarity flag, an output select flag and a reference ratio select (0 selects 512, 1 selects 1024).

A channel raises a one-cycle update strobe when its register is written. It also keeps a sticky flag if a main count below the legal minimum was ever loaded. Neither side has back-pressure. The serial link cannot be stalled, and the outputs are registers that the consumer samples whenever it likes. The strobe only marks a change and needs no acknowledge.

Top module: `dual_ser_cfg_loader`

## Requirements
- R1: After reset, both channel registers read zero on every field, both error flags are low and neither update strobe is asserted.
- R2: Each synchronised rising edge of the serial clock shifts the data level into bit 0 of the word and moves older bits toward bit 22. The first bit sent therefore lands in bit 22. The word layout is: bit 0 routing, bit 1 reference select, bit 2 phase polarity, bit 3 spare (sent low), bit 4 output select, bits 11:5 swallow count, and bits 22:12 main count.
- R3: A rising edge of synchronised load enable with routing bit 1 copies the word into the transmit register, and the receive register keeps its value.
- R4: A rising edge of synchronised load enable with routing bit 0 copies the word into the receive register, and the transmit register keeps its value.
- R5: Each load pulses only the selected channel's update strobe, for exactly one system clock cycle. A channel's outputs never change without its strobe.
- R6: Loading a main count below 16 sets that channel's error flag. The flag stays set through later valid loads until reset, and the other channel's flag is not affected.
- R7: A main count of exactly 16 does not raise the error flag. The extreme values (main count 2047, swallow count 127 and swallow count 0) are presented unaltered.
- R8: Serial clock edges arriving while load enable is held high are still shifted in. A held-high load enable causes only one load, and a later fresh rising edge loads the new contents.
- R9: When a serial clock rising edge and a load enable rising edge land in the same system cycle, the register receives the word as it stood before that shift, and the shift still takes effect.
- R10: Only the last 23 bits shifted before a load matter. Surplus leading bits are pushed out of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Serial load enable, asynchronous |
| tx_n_cnt | output | 11 | Transmit main divide count |
| tx_a_cnt | output | 7 | Transmit swallow count |
| tx_ref_sel | output | 1 | Transmit reference ratio select |
| tx_phase_pol | output | 1 | Transmit phase polarity |
| tx_out_sel | output | 1 | Transmit divider output select |
| tx_upd | output | 1 | Transmit register update strobe |
| tx_n_err | output | 1 | Transmit sticky main-count range error |
| rx_n_cnt | output | 11 | Receive main divide count |
| rx_a_cnt | output | 7 | Receive swallow count |
| rx_ref_sel | output | 1 | Receive reference ratio select |
| rx_phase_pol | output | 1 | Receive phase polarity |
| rx_out_sel | output | 1 | Receive divider output select |
| rx_upd | output | 1 | Receive register update strobe |
| rx_n_err | output | 1 | Receive sticky main-count range error |

## Verification
A shift and a load can fall in the same system cycle. The serial clock and load enable pass through identical synchronisers, so if the bench raises both lines in the same instant, both edges are detected in the same cycle. The bench first loads a known word. It then raises serial clock and load enable together and expects the register to show the pre-shift word. A further load then has to show that the simultaneous bit was still shifted in.

// File: rtl/serload_pkg.sv
package serload_pkg;

  localparam int CFG_N_W    = 11;
  localparam int CFG_A_W    = 7;
  localparam int CFG_CTRL_W = 5;
  localparam int CFG_WORD_W = CFG_N_W + CFG_A_W + CFG_CTRL_W;

  // Word layout, most significant field first (bit 0 = routing bit,
  // which is the last bit transmitted).
  typedef struct packed {
    logic [CFG_N_W-1:0] n_cnt;
    logic [CFG_A_W-1:0] a_cnt;
    logic               out_sel;
    logic               spare;
    logic               phase_pol;
    logic               ref_sel;
    logic               route_tx;
  } cfg_word_t;

  typedef enum logic { CH_RX = 1'b0, CH_TX = 1'b1 } chan_e;

endpackage

// File: rtl/serload_sync.sv
module serload_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= stage_q[STAGES-1];
  end

  assign level = stage_q[STAGES-1];
  assign rise  = stage_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/serload_shifter.sv
module serload_shifter #(
  parameter int WORD_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sreg_q <= '0;
    else if (shift_en) sreg_q <= {sreg_q[WORD_W-2:0], bit_in};
  end

  assign word = sreg_q;

endmodule

// File: rtl/serload_chan.sv
module serload_chan
  import serload_pkg::*;
#(
  parameter chan_e CHAN  = CH_TX,
  parameter int    N_MIN = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  cfg_word_t word_in,
  output cfg_word_t word_q,
  output logic      upd,
  output logic      n_err
);

  logic hit;
  logic n_low;

  assign hit   = load && (word_in.route_tx == logic'(CHAN));
  assign n_low = (int'(word_in.n_cnt) < N_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      upd    <= 1'b0;
      n_err  <= 1'b0;
    end else begin
      upd <= hit;
      if (hit) begin
        word_q <= word_in;
        if (n_low) n_err <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dual_ser_cfg_loader.sv
module dual_ser_cfg_loader
  import serload_pkg::*;
#(
  parameter int N_MIN       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_dat,
  input  logic               ser_le,
  output logic [CFG_N_W-1:0] tx_n_cnt,
  output logic [CFG_A_W-1:0] tx_a_cnt,
  output logic               tx_ref_sel,
  output logic               tx_phase_pol,
  output logic               tx_out_sel,
  output logic               tx_upd,
  output logic               tx_n_err,
  output logic [CFG_N_W-1:0] rx_n_cnt,
  output logic [CFG_A_W-1:0] rx_a_cnt,
  output logic               rx_ref_sel,
  output logic               rx_phase_pol,
  output logic               rx_out_sel,
  output logic               rx_upd,
  output logic               rx_n_err
);

  localparam int LN_CLK = 0;
  localparam int LN_DAT = 1;
  localparam int LN_LE  = 2;
  localparam int NLINES = 3;
  localparam int NCHAN  = 2;

  logic [NLINES-1:0] sync_lvl;
  logic [NLINES-1:0] sync_rise;
  logic [CFG_WORD_W-1:0] shift_word;
  cfg_word_t         chan_word [NCHAN];
  logic              chan_upd  [NCHAN];
  logic              chan_err  [NCHAN];

  serload_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({ser_le, ser_dat, ser_clk}),
    .level    (sync_lvl),
    .rise     (sync_rise)
  );

  serload_shifter #(.WORD_W(CFG_WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (sync_rise[LN_CLK]),
    .bit_in   (sync_lvl[LN_DAT]),
    .word     (shift_word)
  );

  generate
    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
      serload_chan #(
        .CHAN  ((c == 0) ? CH_TX : CH_RX),
        .N_MIN (N_MIN)
      ) u_chan (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sync_rise[LN_LE]),
        .word_in (cfg_word_t'(shift_word)),
        .word_q  (chan_word[c]),
        .upd     (chan_upd[c]),
        .n_err   (chan_err[c])
      );
    end
  endgenerate

  assign tx_n_cnt     = chan_word[0].n_cnt;
  assign tx_a_cnt     = chan_word[0].a_cnt;
  assign tx_ref_sel   = chan_word[0].ref_sel;
  assign tx_phase_pol = chan_word[0].phase_pol;
  assign tx_out_sel   = chan_word[0].out_sel;
  assign tx_upd       = chan_upd[0];
  assign tx_n_err     = chan_err[0];

  assign rx_n_cnt     = chan_word[1].n_cnt;
  assign rx_a_cnt     = chan_word[1].a_cnt;
  assign rx_ref_sel   = chan_word[1].ref_sel;
  assign rx_phase_pol = chan_word[1].phase_pol;
  assign rx_out_sel   = chan_word[1].out_sel;
  assign rx_upd       = chan_upd[1];
  assign rx_n_err     = chan_err[1];

endmodule

// File: rtl/dual_ser_cfg_loader_chk.sv
module dual_ser_cfg_loader_chk #(
  parameter int N_W   = 11,
  parameter int A_W   = 7,
  parameter int N_MIN = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [N_W-1:0] tx_n_cnt,
  input logic [A_W-1:0] tx_a_cnt,
  input logic           tx_upd,
  input logic           tx_n_err,
  input logic [N_W-1:0] rx_n_cnt,
  input logic [A_W-1:0] rx_a_cnt,
  input logic           rx_upd,
  input logic           rx_n_err
);

  AST_UPD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_upd && rx_upd)); // R5

  AST_TX_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_upd |=> !tx_upd); // R5

  AST_RX_UPD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_upd |=> !rx_upd); // R5

  AST_TX_CHANGE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(tx_n_cnt) && $stable(tx_a_cnt)) |-> tx_upd); // R3

  AST_RX_CHANGE_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !($stable(rx_n_cnt) && $stable(rx_a_cnt)) |-> rx_upd); // R4

  AST_TX_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_n_err |=> tx_n_err); // R6

  AST_RX_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_n_err |=> rx_n_err); // R6

  AST_TX_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_n_err) |-> (tx_upd && (int'(tx_n_cnt) < N_MIN))); // R6

  AST_RX_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_n_err) |-> (rx_upd && (int'(rx_n_cnt) < N_MIN))); // R6

endmodule

bind dual_ser_cfg_loader dual_ser_cfg_loader_chk #(
  .N_W   (serload_pkg::CFG_N_W),
  .A_W   (serload_pkg::CFG_A_W),
  .N_MIN (N_MIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_n_cnt (tx_n_cnt),
  .tx_a_cnt (tx_a_cnt),
  .tx_upd   (tx_upd),
  .tx_n_err (tx_n_err),
  .rx_n_cnt (rx_n_cnt),
  .rx_a_cnt (rx_a_cnt),
  .rx_upd   (rx_upd),
  .rx_n_err (rx_n_err)
);

// File: tb/dual_ser_cfg_loader_bench.sv
module dual_ser_cfg_loader_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ser_le = 1'b0;
  logic [10:0] tx_n_cnt, rx_n_cnt;
  logic [6:0]  tx_a_cnt, rx_a_cnt;
  logic tx_ref_sel, tx_phase_pol, tx_out_sel, tx_upd, tx_n_err;
  logic rx_ref_sel, rx_phase_pol, rx_out_sel, rx_upd, rx_n_err;

  int n_checks = 0;
  int n_fails  = 0;
  int tx_pulses = 0;
  int rx_pulses = 0;

  always #5 clk = ~clk;

  dual_ser_cfg_loader u_dual_ser_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .tx_n_cnt(tx_n_cnt), .tx_a_cnt(tx_a_cnt), .tx_ref_sel(tx_ref_sel),
    .tx_phase_pol(tx_phase_pol), .tx_out_sel(tx_out_sel), .tx_upd(tx_upd), .tx_n_err(tx_n_err),
    .rx_n_cnt(rx_n_cnt), .rx_a_cnt(rx_a_cnt), .rx_ref_sel(rx_ref_sel),
    .rx_phase_pol(rx_phase_pol), .rx_out_sel(rx_out_sel), .rx_upd(rx_upd), .rx_n_err(rx_n_err)
  );

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (tx_upd) tx_pulses++;
    if (rx_upd) rx_pulses++;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [22:0] mk(input int n, input int a, input bit osel,
                                      input bit ph, input bit rsel, input bit to_tx);
    logic [22:0] w;
    w = {n[10:0], a[6:0], osel, 1'b0, ph, rsel, to_tx};
    return w;
  endfunction

  task automatic shift_bit(input bit b);
    @(negedge clk); ser_dat = b;
    repeat (3) @(negedge clk); ser_clk = 1'b1;
    repeat (3) @(negedge clk); ser_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic shift_word(input logic [22:0] w);
    for (int i = 22; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_le();
    @(negedge clk); ser_le = 1'b1;
    repeat (6) @(negedge clk); ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic send(input logic [22:0] w);
    shift_word(w);
    pulse_le();
  endtask

  task automatic check_tx(input string req, input logic [22:0] w);
    check(req, tx_n_cnt, w[22:12]);
    check(req, tx_a_cnt, w[11:5]);
    check(req, tx_out_sel, w[4]);
    check(req, tx_phase_pol, w[2]);
    check(req, tx_ref_sel, w[1]);
  endtask

  task automatic check_rx(input string req, input logic [22:0] w);
    check(req, rx_n_cnt, w[22:12]);
    check(req, rx_a_cnt, w[11:5]);
    check(req, rx_out_sel, w[4]);
    check(req, rx_phase_pol, w[2]);
    check(req, rx_ref_sel, w[1]);
  endtask

  logic [22:0] tx_exp = '0;
  logic [22:0] rx_exp = '0;

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    tx_exp = '0;
    rx_exp = '0;
  endtask

  task automatic t_reset_state();
    check_tx("R1 tx after reset", '0);
    check_rx("R1 rx after reset", '0);
    check("R1 tx err", tx_n_err, 0);
    check("R1 rx err", rx_n_err, 0);
    check("R1 tx strobe", tx_upd, 0);
    check("R1 rx strobe", rx_upd, 0);
  endtask

  task automatic t_tx_load();
    int t0 = tx_pulses, r0 = rx_pulses;
    tx_exp = mk(1000, 85, 1, 0, 1, 1);
    send(tx_exp);
    check_tx("R2 R3 tx fields", tx_exp);
    check_rx("R3 rx untouched", rx_exp);
    check("R5 tx one strobe", tx_pulses - t0, 1);
    check("R5 rx no strobe", rx_pulses - r0, 0);
  endtask

  task automatic t_rx_load();
    int t0 = tx_pulses, r0 = rx_pulses;
    rx_exp = mk(300, 3, 0, 1, 0, 0);
    send(rx_exp);
    check_rx("R2 R4 rx fields", rx_exp);
    check_tx("R4 tx untouched", tx_exp);
    check("R5 rx one strobe", rx_pulses - r0, 1);
    check("R5 tx no strobe", tx_pulses - t0, 0);
  endtask

  task automatic t_bounds();
    rx_exp = mk(16, 127, 1, 1, 1, 0);
    send(rx_exp);
    check_rx("R7 rx n=16 a=127", rx_exp);
    check("R7 rx err at 16", rx_n_err, 0);
    tx_exp = mk(2047, 0, 0, 1, 0, 1);
    send(tx_exp);
    check_tx("R7 tx n=2047 a=0", tx_exp);
    check("R7 tx err at 2047", tx_n_err, 0);
    tx_exp = mk(15, 9, 0, 0, 0, 1);
    send(tx_exp);
    check("R6 tx err at 15", tx_n_err, 1);
    check("R6 rx err unaffected", rx_n_err, 0);
    tx_exp = mk(500, 9, 1, 0, 1, 1);
    send(tx_exp);
    check_tx("R6 tx valid after err", tx_exp);
    check("R6 tx err sticky", tx_n_err, 1);
  endtask

  task automatic t_le_held();
    logic [22:0] w = mk(777, 44, 1, 1, 0, 0);
    logic [22:0] before_rx;
    int total0 = tx_pulses + rx_pulses;
    @(negedge clk); ser_le = 1'b1;
    repeat (6) @(negedge clk);
    shift_word(w);
    repeat (6) @(negedge clk);
    check("R8 single load while held", tx_pulses + rx_pulses - total0, 1);
    before_rx = {rx_n_cnt, rx_a_cnt, rx_out_sel, 1'b0, rx_phase_pol, rx_ref_sel, 1'b0};
    check("R8 no reload while held", (before_rx == w) ? 1 : 0, 0);
    @(negedge clk); ser_le = 1'b0;
    repeat (6) @(negedge clk);
    pulse_le();
    rx_exp = w;
    check_rx("R8 shifted while held", rx_exp);
  endtask

  task automatic t_overlong();
    tx_exp = mk(1234, 100, 0, 1, 1, 1);
    shift_bit(1'b1);
    shift_bit(1'b0);
    shift_bit(1'b1);
    send(tx_exp);
    check_tx("R10 last 23 bits kept", tx_exp);
  endtask

  task automatic t_collide();
    logic [22:0] w = mk(640, 17, 1, 0, 1, 1);
    logic [22:0] nxt;
    shift_word(w);
    @(negedge clk);
    ser_dat = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    ser_le  = 1'b1;
    repeat (6) @(negedge clk);
    ser_clk = 1'b0;
    ser_le  = 1'b0;
    repeat (6) @(negedge clk);
    tx_exp = w;
    check_tx("R9 pre-shift word latched", tx_exp);
    // shift now holds w<<1|1: routing bit 1, so a fresh load goes to tx
    nxt = {w[21:0], 1'b1};
    pulse_le();
    check_tx("R9 colliding bit still shifted", nxt);
  endtask

  task automatic t_reset_clears();
    do_reset();
    check("R1 R6 tx err cleared", tx_n_err, 0);
    check_tx("R1 tx cleared", '0);
    check_rx("R1 rx cleared", '0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_tx_load();
    t_rx_load();
    t_bounds();
    t_le_held();
    t_overlong();
    t_collide();
    t_reset_clears();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule